// File: doc/BRIEF.md
# Asynchronous Serial Byte Transmitter

This block turns parallel bytes into an asynchronous serial stream on one output line. Each frame is a low start bit, eight data bits least significant first, and one or two high stop bits, with no parity. A parameter selects the stop-bit count. Two stop bits are the default because they give the receiver more margin. One stop bit gives ten line bits per byte, which is 80% line efficiency. The block does not divide the clock itself. It advances only on clocks where the bit-rate enable input `bit_tick` is high, and that input is produced elsewhere at the baud rate.

Between frames the line rests high for as long as needed. A frame begins on the first bit tick that finds both the enable and the send request high. The byte on the data input is captured on that tick. If the send request is still high on the tick that begins the final stop bit, frames chain back to back. That tick is the one on which `done` rises. The data input is sampled again on that tick, and the next start bit follows the last stop bit with no idle gap. A byte changed after that tick arrives too late, and the previous value is sent again. Dropping the enable aborts any frame in flight.

Top module: `serial_byte_tx`

## Requirements
- R1: While reset is asserted and right after it is released, with enable high, the line is high and busy and done are low.
- R2: While idle with no send request, bit ticks leave the line high and busy low indefinitely. After a frame with no chained byte, the block returns to this state.
- R3: On a bit tick with enable and send request high in idle, the data byte is captured. For the next bit period the line is low (start bit) and busy is high.
- R4: After the start bit, the line carries the captured byte's bit 0, then bit 1 up to bit 7. Each bit lasts one bit period, and bit 0 follows the start bit.
- R5: After bit 7 the line is high for STOP_BITS bit periods, where STOP_BITS is 1 or 2.
- R6: done is high exactly during the final stop-bit period and only while busy. Busy stays high from the start bit through the last stop bit.
- R7: If the send request is high on the tick that begins the final stop bit, the data input is captured on that tick. The following tick begins a new start bit with busy still high.
- R8: A data byte that changes after that capture tick is not used; the byte value present on the capture tick is the one sent.
- R9: When enable goes low, the line goes high at once, and busy is low from the next clock on. The frame is abandoned.
- R10: A send request while enable is low starts no frame.
- R11: Between bit ticks, with enable steady high, the line, busy and done do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-clock pulse per bit period |
| tx_enable | input | 1 | Transmitter enable; low aborts and holds idle |
| send_req | input | 1 | Send request; held high chains frames |
| tx_byte | input | 8 | Byte to send |
| line_out | output | 1 | Serial line, high when idle |
| busy | output | 1 | High from start bit to end of stop bits |
| done | output | 1 | High during the final stop bit |

## Verification
The hardest situation to reach from the ports is the narrow window of back-to-back frames. The next byte counts only if it is present on the one tick that begins the final stop bit, so a byte that arrives later causes the old one to be sent again. The bench drives bit ticks itself, so it knows which tick that is. On random chained bursts it either presents the new byte before that tick or only after it, and predicts the resent byte in the late case. Both stop-bit settings run side by side, and an abort in the middle of a data bit covers the enable path.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_e;

endpackage

// File: rtl/ser_tx_seq.sv
module ser_tx_seq
  import ser_tx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      enable,
  input  logic      req,
  output tx_state_e state,
  output logic      load,
  output logic      shift,
  output logic      busy,
  output logic      done
);

  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int SW = (STOP_BITS > 1) ? $clog2(STOP_BITS) : 1;
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_BITS - 1);
  localparam logic [SW-1:0] LAST_STOP = SW'(STOP_BITS - 1);
  localparam bit ONE_STOP = (STOP_BITS == 1);

  tx_state_e      st_q, st_d;
  logic [BW-1:0]  bc_q, bc_d;
  logic [SW-1:0]  sc_q, sc_d;
  logic           pend_q, pend_d;
  logic [SW-1:0]  sc_inc;

  assign sc_inc = sc_q + SW'(1);

  // next-state logic
  always_comb begin
    st_d   = st_q;
    bc_d   = bc_q;
    sc_d   = sc_q;
    pend_d = pend_q;
    load   = 1'b0;
    shift  = 1'b0;
    if (!enable) begin
      st_d   = TX_IDLE;
      bc_d   = '0;
      sc_d   = '0;
      pend_d = 1'b0;
    end else if (tick) begin
      unique case (st_q)
        TX_IDLE: begin
          if (req) begin
            load = 1'b1;
            st_d = TX_START;
          end
        end
        TX_START: begin
          st_d = TX_DATA;
          bc_d = '0;
        end
        TX_DATA: begin
          shift = 1'b1;
          if (bc_q == LAST_BIT) begin
            st_d = TX_STOP;
            sc_d = '0;
            bc_d = '0;
            if (ONE_STOP && req) begin
              load   = 1'b1;
              pend_d = 1'b1;
            end
          end else begin
            bc_d = bc_q + BW'(1);
          end
        end
        TX_STOP: begin
          if (sc_q == LAST_STOP) begin
            pend_d = 1'b0;
            sc_d   = '0;
            st_d   = pend_q ? TX_START : TX_IDLE;
          end else begin
            sc_d = sc_inc;
            if ((sc_inc == LAST_STOP) && req) begin
              load   = 1'b1;
              pend_d = 1'b1;
            end
          end
        end
        default: st_d = TX_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      bc_q   <= '0;
      sc_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bc_q   <= bc_d;
      sc_q   <= sc_d;
      pend_q <= pend_d;
    end
  end

  assign state = st_q;
  assign busy  = (st_q != TX_IDLE);
  assign done  = (st_q == TX_STOP) && (sc_q == LAST_STOP);

endmodule

// File: rtl/ser_tx_shreg.sv
module ser_tx_shreg #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 shift,
  input  logic [DATA_BITS-1:0] din,
  output logic                 lsb
);

  logic [DATA_BITS-1:0] q;
  logic [DATA_BITS-1:0] d;
  logic                 en;

  assign en = load | shift;

  // each stage takes the new byte on load, its upper neighbour on shift
  for (genvar i = 0; i < DATA_BITS; i++) begin : g_stage
    if (i == DATA_BITS - 1) begin : g_top
      assign d[i] = load ? din[i] : 1'b0;
    end else begin : g_mid
      assign d[i] = load ? din[i] : q[i+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

  assign lsb = q[0];

endmodule

// File: rtl/ser_tx_line.sv
module ser_tx_line
  import ser_tx_pkg::*;
(
  input  logic      enable,
  input  tx_state_e state,
  input  logic      data_bit,
  output logic      line
);

  always_comb begin
    if (!enable) begin
      line = 1'b1;
    end else begin
      unique case (state)
        TX_START: line = 1'b0;
        TX_DATA:  line = data_bit;
        default:  line = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/serial_byte_tx.sv
module serial_byte_tx
  import ser_tx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_tick,
  input  logic                 tx_enable,
  input  logic                 send_req,
  input  logic [DATA_BITS-1:0] tx_byte,
  output logic                 line_out,
  output logic                 busy,
  output logic                 done
);

  tx_state_e state;
  logic      load;
  logic      shift;
  logic      data_bit;

  ser_tx_seq #(
    .DATA_BITS(DATA_BITS),
    .STOP_BITS(STOP_BITS)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (bit_tick),
    .enable(tx_enable),
    .req   (send_req),
    .state (state),
    .load  (load),
    .shift (shift),
    .busy  (busy),
    .done  (done)
  );

  ser_tx_shreg #(
    .DATA_BITS(DATA_BITS)
  ) u_shreg (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .shift(shift),
    .din  (tx_byte),
    .lsb  (data_bit)
  );

  ser_tx_line u_line (
    .enable  (tx_enable),
    .state   (state),
    .data_bit(data_bit),
    .line    (line_out)
  );

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_enable,
  input logic line_out,
  input logic busy,
  input logic done
);

  // R2: an idle transmitter holds the line at mark
  p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_out);

  // R3: the first busy cycle shows the start bit
  p_start_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy) && tx_enable) |-> !line_out);

  // R6: done only inside a frame
  p_done_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R6: done never survives the tick that ends the final stop bit
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> !$past(bit_tick));

  // R9: a cycle with enable low leaves the block idle
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tx_enable)) |-> !busy);

  // R9: line forced to mark while disabled
  p_abort_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> line_out);

  // R11: nothing moves without a bit tick
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bit_tick) && $past(tx_enable) && tx_enable)
      |-> ($stable(line_out) && $stable(busy) && $stable(done)));

endmodule

bind serial_byte_tx ser_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_tick (bit_tick),
  .tx_enable(tx_enable),
  .line_out (line_out),
  .busy     (busy),
  .done     (done)
);

// File: tb/sim_serial_byte_tx.sv
`timescale 1ns/1ps
module sim_serial_byte_tx;

  logic       clk;
  logic       rst_n;
  logic       bit_tick;
  logic       en   [2];
  logic       req  [2];
  logic [7:0] dat  [2];
  logic       line [2];
  logic       bsy  [2];
  logic       dn   [2];

  int n_run  = 0;
  int n_fail = 0;
  bit fin    = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  serial_byte_tx #(.DATA_BITS(8), .STOP_BITS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_enable(en[0]),
    .send_req(req[0]), .tx_byte(dat[0]), .line_out(line[0]),
    .busy(bsy[0]), .done(dn[0]));

  serial_byte_tx #(.DATA_BITS(8), .STOP_BITS(1)) u1 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_enable(en[1]),
    .send_req(req[1]), .tx_byte(dat[1]), .line_out(line[1]),
    .busy(bsy[1]), .done(dn[1]));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected line level in slot s of a frame: start, 8 data, stops
  function automatic logic slot_level(input logic [7:0] b, input int s);
    if (s == 0) return 1'b0;
    if (s <= 8) return b[s-1];
    return 1'b1;
  endfunction

  task automatic tick();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  // one burst of n chained frames on unit u, first byte given
  task automatic burst(input int u, input int n, input bit allow_late, input logic [7:0] first);
    int         nst;
    logic [7:0] cur;
    logic [7:0] nb;
    logic [7:0] held;
    bit         late;
    nst = (u == 0) ? 2 : 1;
    cur = first;
    dat[u] = first;
    req[u] = 1'b1;
    tick();
    chk("R3 start bit line", {7'd0, line[u]}, 8'd0);
    chk("R3 busy at start", {7'd0, bsy[u]}, 8'd1);
    repeat (2) @(negedge clk);
    chk("R11 line held between ticks", {7'd0, line[u]}, 8'd0);
    for (int k = 0; k < n; k++) begin
      for (int i = 1; i <= 8; i++) begin
        tick();
        chk("R4 data bit", {7'd0, line[u]}, {7'd0, slot_level(cur, i)});
        chk("R6 busy in data", {7'd0, bsy[u] & ~dn[u]}, 8'd1);
      end
      for (int s = 0; s < nst; s++) begin
        late = 1'b0;
        held = cur;
        if (s == nst - 1) begin
          if (k < n - 1) begin
            nb   = 8'($urandom);
            late = allow_late && ($urandom % 2 == 1);
            if (!late) dat[u] = nb;
            held = dat[u];
            req[u] = 1'b1;
          end else begin
            req[u] = 1'b0;
          end
        end
        tick();
        chk("R5 stop bit level", {7'd0, line[u]}, 8'd1);
        chk("R6 done in final stop only", {7'd0, dn[u]}, {7'd0, (s == nst - 1)});
        if (s == nst - 1 && k < n - 1) begin
          if (late) dat[u] = nb;
          cur = held;
          req[u] = $urandom % 2;
        end
      end
      tick();
      if (k < n - 1) begin
        chk("R7 chained start bit", {7'd0, line[u]}, 8'd0);
        chk("R7 busy continuous", {7'd0, bsy[u]}, 8'd1);
      end else begin
        req[u] = 1'b0;
        chk("R2 back to idle line", {7'd0, line[u]}, 8'd1);
        chk("R2 busy low after frame", {7'd0, bsy[u]}, 8'd0);
      end
    end
  endtask

  // late-byte directed case: resend of the old byte checked bit by bit
  task automatic late_case();
    logic [7:0] got;
    dat[0] = 8'h45;
    req[0] = 1'b1;
    tick();
    for (int i = 0; i < 9; i++) tick();   // 8 data + first stop
    tick();                               // enters final stop, captures 0x45
    dat[0] = 8'hB1;
    req[0] = 1'b0;
    tick();                               // new start bit
    chk("R8 chained start", {7'd0, line[0]}, 8'd0);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      tick();
      got[i] = line[0];
    end
    chk("R8 late byte resends old value", got, 8'h45);
    repeat (2) tick();
    tick();
    chk("R8 idle after resend", {7'd0, bsy[0]}, 8'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    bit_tick = 1'b0;
    rst_n    = 1'b0;
    for (int u = 0; u < 2; u++) begin
      en[u]  = 1'b1;
      req[u] = 1'b0;
      dat[u] = 8'h00;
    end
    repeat (3) @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk("R1 reset line", {7'd0, line[u]}, 8'd1);
      chk("R1 reset busy", {7'd0, bsy[u]}, 8'd0);
      chk("R1 reset done", {7'd0, dn[u]}, 8'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release busy", {7'd0, bsy[0]}, 8'd0);

    repeat (5) tick();
    chk("R2 idle without request", {7'd0, line[0] & ~bsy[0]}, 8'd1);

    // directed corner bytes, both stop settings
    burst(0, 1, 1'b0, 8'h45);
    burst(1, 1, 1'b0, 8'h45);
    burst(0, 2, 1'b0, 8'h00);
    burst(1, 2, 1'b0, 8'hFF);
    burst(1, 3, 1'b0, 8'h80);
    late_case();

    // abort in the middle of a data bit
    dat[0] = 8'hA5;
    req[0] = 1'b1;
    tick();
    req[0] = 1'b0;
    repeat (3) tick();
    @(negedge clk);
    en[0] = 1'b0;
    #1;
    chk("R9 line forced high", {7'd0, line[0]}, 8'd1);
    @(negedge clk);
    chk("R9 busy dropped", {7'd0, bsy[0]}, 8'd0);

    // request while disabled
    req[0] = 1'b1;
    repeat (3) tick();
    chk("R10 no frame while disabled", {7'd0, bsy[0]}, 8'd0);
    chk("R10 line idle while disabled", {7'd0, line[0]}, 8'd1);
    req[0] = 1'b0;
    en[0]  = 1'b1;
    tick();
    chk("R10 no stale start", {7'd0, bsy[0]}, 8'd0);
    chk("R2 idle after abort", {7'd0, line[0]}, 8'd1);

    // random bursts
    for (int r = 0; r < 40; r++) begin
      burst($urandom % 2, 1 + ($urandom % 4), 1'b1, 8'($urandom));
      repeat ($urandom % 3) tick();
    end

    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule